// File: doc/BRIEF.md
# PHY Preamble and Header Generator

This transmit-side framer produces the serial bit stream that goes ahead of a packet's payload. It sends a synchronization field, a 16-bit start frame delimiter and a 48-bit header. The header carries a signal byte, a service byte and a 16-bit length word, followed by a CCITT CRC-16 that the block works out bit by bit over those three fields as they leave. The bits go out before any scrambling or modulation. The header never leaves the block unprotected, so the controller does not need to compute the CRC.

The block has two preamble modes. In long mode the sync field is all ones, and its length is set by a configuration count. In short mode the sync field is 56 zeros and the delimiter is sent in reverse bit order. Raising the transmit enable captures the configuration and starts a frame. Each symbol strobe then moves the output on by one bit. A phase code shows which part of the frame is on the line. A rate flag marks the short-mode header, which runs at the faster rate, and a done flag tells the payload path it may take over. Lowering the enable ends the frame at any point.

Top module: `phy_hdr_gen`

## Requirements
- R1: In long mode (cfg_short=0) the sync field is cfg_sync_len one bits, where a value of 0 means 256 bits.
- R2: In short mode (cfg_short=1) the sync field is 56 zero bits.
- R3: The delimiter is 16 bits. In long mode delimiter bit k is bit k of 16'hF3A0, for k=0..15, so the value goes out LSB first. In short mode bit k is bit 15-k of 16'hF3A0.
- R4: The header's first 32 bits are the signal byte, then the service byte, then the length word, each sent LSB first.
- R5: The last 16 header bits are the ones complement of the CRC, sent MSB first. The CRC uses polynomial x^16+x^12+x^5+1 (0x1021), is preset to 0xFFFF and is fed the 32 field bits in transmit order.
- R6: The output bit advances exactly once per cycle in which sym_stb is high. A strobe in the cycle that starts a frame, or while the phase is done, has no effect.
- R7: The phase codes are 0 idle, 1 sync, 2 delimiter, 3 header and 4 done. After the 48th header bit the phase is 4, hdr_done is 1 and tx_bit is 0 until the enable falls.
- R8: When tx_en is low, the next cycle shows phase 0, tx_bit 0 and all flags low. The configuration is captured in the cycle that starts the frame, so later changes do not affect the frame in progress.
- R9: fast_rate is 1 exactly while the phase is header in a short-mode frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit enable; a rising level starts a frame, low aborts it |
| sym_stb | input | 1 | Symbol strobe; moves the output to the next bit |
| cfg_short | input | 1 | 1 selects short preamble mode |
| cfg_sync_len | input | 8 | Long-mode sync length in symbols (0 = 256) |
| cfg_signal | input | 8 | Signal field value |
| cfg_service | input | 8 | Service field value |
| cfg_length | input | 16 | Length field value |
| tx_bit | output | 1 | Current serial bit |
| phase | output | 3 | Active phase code |
| fast_rate | output | 1 | Short-mode header rate marker |
| hdr_done | output | 1 | Header complete; payload may follow |

## Verification
Some rules are checked by assertions on every cycle. These are the polarity of the sync bits in each mode, the order in which phases may follow one another, that output is held when there is no strobe, the return to idle after the enable drops, the zero output while done, and the rate flag's confinement to the header phase. The bit values themselves need the scenarios: the delimiter orientation, the LSB-first field order and the complemented CRC. The bench compares these against a behavioural model over long, short, shortest and 256-symbol preambles, under irregular strobes, aborts mid-header and configuration changes during a frame.

// File: rtl/phg_pkg.sv
package phg_pkg;
    localparam int CNT_W = 8;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_SYNC = 3'd1,
        PH_SFD  = 3'd2,
        PH_HDR  = 3'd3,
        PH_DONE = 3'd4
    } phase_e;

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic             short_m;
        logic [CNT_W-1:0] sync_last;
        logic [31:0]      fields;
        logic [15:0]      crc;
    } gen_state_t;
endpackage

// File: rtl/phg_crc16.sv
module phg_crc16 #(
    parameter int          WIDTH = 16,
    parameter logic [15:0] POLY  = 16'h1021
) (
    input  logic [WIDTH-1:0] crc_in,
    input  logic             din,
    output logic [WIDTH-1:0] crc_out
);
    logic fb;
    always_comb begin
        fb      = crc_in[WIDTH-1] ^ din;
        crc_out = {crc_in[WIDTH-2:0], 1'b0} ^ (fb ? POLY[WIDTH-1:0] : '0);
    end
endmodule

// File: rtl/phg_bitsel.sv
module phg_bitsel
    import phg_pkg::*;
#(
    parameter logic [15:0] SFD_LONG = 16'hF3A0,
    parameter int          DATA_BITS = 32
) (
    input  phase_e           ph,
    input  logic [CNT_W-1:0] cnt,
    input  logic             short_m,
    input  logic [31:0]      fields,
    input  logic [15:0]      crc,
    output logic             bit_o
);
    logic [3:0] k;
    always_comb begin
        k = cnt[3:0];
        case (ph)
            PH_SYNC: bit_o = ~short_m;
            PH_SFD:  bit_o = short_m ? SFD_LONG[4'd15 - k] : SFD_LONG[k];
            PH_HDR:  bit_o = (cnt < CNT_W'(DATA_BITS)) ? fields[cnt[4:0]]
                                                       : ~crc[4'd15 - k];
            default: bit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/phy_hdr_gen.sv
module phy_hdr_gen
    import phg_pkg::*;
#(
    parameter int          SHORT_SYNC = 56,
    parameter int          SFD_BITS   = 16,
    parameter int          DATA_BITS  = 32,
    parameter int          CRC_BITS   = 16,
    parameter logic [15:0] SFD_LONG   = 16'hF3A0,
    parameter logic [15:0] CRC_POLY   = 16'h1021
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tx_en,
    input  logic        sym_stb,
    input  logic        cfg_short,
    input  logic [7:0]  cfg_sync_len,
    input  logic [7:0]  cfg_signal,
    input  logic [7:0]  cfg_service,
    input  logic [15:0] cfg_length,
    output logic        tx_bit,
    output logic [2:0]  phase,
    output logic        fast_rate,
    output logic        hdr_done
);
    localparam int HDR_BITS = DATA_BITS + CRC_BITS;
    localparam logic [CNT_W-1:0] SFD_LAST   = CNT_W'(SFD_BITS - 1);
    localparam logic [CNT_W-1:0] HDR_LAST   = CNT_W'(HDR_BITS - 1);
    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_SYNC - 1);
    localparam logic [CNT_W-1:0] DATA_END   = CNT_W'(DATA_BITS);

    gen_state_t st_q, st_d;
    logic [15:0] crc_nx;
    logic        cur_bit;

    phg_crc16 #(.WIDTH(16), .POLY(CRC_POLY)) i_crc (
        .crc_in(st_q.crc), .din(cur_bit), .crc_out(crc_nx)
    );

    phg_bitsel #(.SFD_LONG(SFD_LONG), .DATA_BITS(DATA_BITS)) i_sel (
        .ph(st_q.ph), .cnt(st_q.cnt), .short_m(st_q.short_m),
        .fields(st_q.fields), .crc(st_q.crc), .bit_o(cur_bit)
    );

    always_comb begin
        st_d = st_q;
        if (!tx_en) begin
            st_d.ph  = PH_IDLE;
            st_d.cnt = '0;
        end else begin
            case (st_q.ph)
                PH_IDLE: begin
                    st_d.ph        = PH_SYNC;
                    st_d.cnt       = '0;
                    st_d.short_m   = cfg_short;
                    st_d.sync_last = cfg_short ? SHORT_LAST
                                               : CNT_W'(cfg_sync_len - 8'd1);
                    st_d.fields    = {cfg_length, cfg_service, cfg_signal};
                    st_d.crc       = 16'hFFFF;
                end
                PH_SYNC: if (sym_stb) begin
                    if (st_q.cnt == st_q.sync_last) begin
                        st_d.ph  = PH_SFD;
                        st_d.cnt = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                PH_SFD: if (sym_stb) begin
                    if (st_q.cnt == SFD_LAST) begin
                        st_d.ph  = PH_HDR;
                        st_d.cnt = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                PH_HDR: if (sym_stb) begin
                    if (st_q.cnt < DATA_END) st_d.crc = crc_nx;
                    if (st_q.cnt == HDR_LAST) begin
                        st_d.ph  = PH_DONE;
                        st_d.cnt = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, cnt: '0, short_m: 1'b0, sync_last: '0,
                      fields: '0, crc: 16'hFFFF};
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_bit    = cur_bit;
    assign phase     = st_q.ph;
    assign fast_rate = st_q.short_m && (st_q.ph == PH_HDR);
    assign hdr_done  = (st_q.ph == PH_DONE);

    AST_IDLE_AFTER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (phase == 3'd0 && !tx_bit && !fast_rate && !hdr_done)); // R8
    AST_HOLD_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && !sym_stb && phase != 3'd0) |=> ($stable(tx_bit) && $stable(phase))); // R6
    AST_LONG_SYNC_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd1 && !st_q.short_m) |-> tx_bit); // R1
    AST_SHORT_SYNC_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd1 && st_q.short_m) |-> !tx_bit); // R2
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_done |-> (!tx_bit && !fast_rate)); // R7
    AST_SYNC_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd1) |=> (phase == 3'd1 || phase == 3'd2 || phase == 3'd0)); // R7
    AST_SFD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd2) |=> (phase == 3'd2 || phase == 3'd3 || phase == 3'd0)); // R7
    AST_FAST_IN_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        fast_rate |-> (phase == 3'd3)); // R9
endmodule

// File: tb/test_phy_hdr_gen.sv
module test_phy_hdr_gen;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_en = 1'b0, sym_stb = 1'b0, cfg_short = 1'b0;
    logic [7:0] cfg_sync_len = 8'd128, cfg_signal = 8'h0A, cfg_service = 8'h00;
    logic [15:0] cfg_length = 16'h0100;
    logic tx_bit, fast_rate, hdr_done;
    logic [2:0] phase;

    int n_chk = 0, n_fail = 0, cycles = 0;

    int  exp_bit[$];
    int  exp_ph[$];
    bit  ref_active = 0;
    bit  ref_short = 0;
    int  idx = 0;

    always #4 clk = ~clk;

    phy_hdr_gen i_phy_hdr_gen (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .sym_stb(sym_stb),
        .cfg_short(cfg_short), .cfg_sync_len(cfg_sync_len),
        .cfg_signal(cfg_signal), .cfg_service(cfg_service),
        .cfg_length(cfg_length), .tx_bit(tx_bit), .phase(phase),
        .fast_rate(fast_rate), .hdr_done(hdr_done)
    );

    task automatic build_frame();
        logic [15:0] sfd = 16'hF3A0;
        logic [31:0] f = {cfg_length, cfg_service, cfg_signal};
        logic [15:0] c = 16'hFFFF;
        int nsync;
        exp_bit.delete();
        exp_ph.delete();
        ref_short = cfg_short;
        nsync = cfg_short ? 56 : ((cfg_sync_len == 0) ? 256 : int'(cfg_sync_len));
        for (int i = 0; i < nsync; i++) begin            // R1 R2
            exp_bit.push_back(cfg_short ? 0 : 1);
            exp_ph.push_back(1);
        end
        for (int i = 0; i < 16; i++) begin               // R3
            exp_bit.push_back(cfg_short ? int'(sfd[15-i]) : int'(sfd[i]));
            exp_ph.push_back(2);
        end
        for (int i = 0; i < 32; i++) begin               // R4
            bit b = f[i];
            exp_bit.push_back(int'(b));
            exp_ph.push_back(3);
            if (c[15] ^ b) c = (c << 1) ^ 16'h1021;      // R5
            else c = c << 1;
        end
        c = ~c;
        for (int i = 15; i >= 0; i--) begin
            exp_bit.push_back(int'(c[i]));
            exp_ph.push_back(3);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_active <= 0;
        end else begin
            if (!tx_en) ref_active = 0;
            else if (!ref_active) begin
                build_frame();
                ref_active = 1;
                idx = 0;
            end else if (sym_stb && idx < exp_bit.size()) idx++;   // R6
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            int eb, ep;
            string req;
            if (!ref_active) begin eb = 0; ep = 0; req = "R8"; end
            else if (idx >= exp_bit.size()) begin eb = 0; ep = 4; req = "R7"; end
            else begin
                eb = exp_bit[idx]; ep = exp_ph[idx];
                case (ep)
                    1: req = ref_short ? "R2" : "R1";
                    2: req = "R3";
                    default: req = (idx >= exp_bit.size() - 16) ? "R5" : "R4";
                endcase
            end
            n_chk++;
            if (int'(tx_bit) != eb || int'(phase) != ep ||
                fast_rate != (ref_short && ep == 3 && ref_active) ||
                hdr_done != (ep == 4)) begin
                n_fail++;
                $display("FAIL %s/R6/R9 idx=%0d bit=%0d exp=%0d phase=%0d exp=%0d fast=%0d done=%0d",
                         req, idx, tx_bit, eb, phase, ep, fast_rate, hdr_done);
            end
        end
    end

    task automatic run_frame(input int gap, input int stop_after);
        int sent = 0;
        @(negedge clk) tx_en = 1'b1;
        @(negedge clk);
        cfg_sync_len = cfg_sync_len ^ 8'h5A;   // R8: change after capture
        cfg_signal   = ~cfg_signal;
        while (sent < stop_after) begin
            sym_stb = ((sent % gap) == 0) || (gap == 3 && ($urandom % 2) == 1);
            @(negedge clk);
            sent++;
        end
        sym_stb = 1'b0;
        repeat (3) @(negedge clk);
        tx_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog cycles=%0d exp=<150000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        n_chk++;
        if (tx_bit !== 1'b0 || phase !== 3'd0 || fast_rate !== 1'b0 || hdr_done !== 1'b0) begin
            n_fail++;
            $display("FAIL R8 reset bit=%0d phase=%0d exp 0/0", tx_bit, phase);
        end
        rst_n = 1'b1;
        @(negedge clk);
        cfg_short = 0; cfg_sync_len = 8'd128; cfg_signal = 8'h0A; cfg_service = 8'h00; cfg_length = 16'h0100;
        run_frame(1, 200);
        cfg_short = 0; cfg_sync_len = 8'd1; cfg_signal = 8'h6E; cfg_service = 8'h80; cfg_length = 16'hBEEF;
        run_frame(2, 160);
        cfg_short = 1; cfg_sync_len = 8'd9; cfg_signal = 8'h14; cfg_service = 8'h04; cfg_length = 16'h1234;
        run_frame(3, 400);
        cfg_short = 0; cfg_sync_len = 8'd0; cfg_signal = 8'hFF; cfg_service = 8'hFF; cfg_length = 16'hFFFF;
        run_frame(1, 330);
        cfg_short = 1; cfg_signal = 8'h37; cfg_service = 8'h00; cfg_length = 16'h0001;
        run_frame(1, 90);                       // abort inside header, R8
        cfg_short = 0; cfg_sync_len = 8'd3; cfg_signal = 8'h00; cfg_service = 8'h00; cfg_length = 16'h0000;
        run_frame(1, 80);
        finish_run();
    end
endmodule